// File: doc/BRIEF.md
# Synchronous Serial Audio Receiver

This block turns one serial data line into parallel words and queues them in a four-entry receive FIFO that is read through a valid/ready port. All of its logic runs on the system clock. The serial bit clock and frame sync are oversampled: a falling edge on the selected bit clock marks one bit. That bit clock and frame sync come from one of two pairs of lines. The receiver either uses its own pair, or, in synchronous operation, borrows the pair that belongs to the transmit side.

There are three ways to find word boundaries. Normal framing takes one word per frame sync. Network framing takes a run of consecutive time slots, and only the slots that are enabled are stored. Gated-clock capture has no frame sync at all: every group of word-length bit-clock edges forms a word, and pauses in the clock between groups do not matter.

Software-visible settings are plain input ports: word length, frame-sync position, number of slots and the slot enable mask. A frame sync can be one bit long or a whole word long. Each stored word carries the number of the slot it arrived in.

Top module: `ssa_rx`

## Requirements
- R1: `cfg_wlen` selects the word length: 0 gives 8 bits, 1 gives 10, 2 gives 12 and 3 gives 16. Data is sampled on the falling edge of the bit clock and assembled MSB first. The word is right-justified in `out_word` and all bits above the word length read zero.
- R2: With `cfg_sync`=1 the receiver takes its bit clock and frame sync from `tx_bclk`/`tx_fs`, and `rx_bclk`/`rx_fs` have no effect. With `cfg_sync`=0 it uses `rx_bclk`/`rx_fs`.
- R3: With `cfg_early`=1 the first data bit is the one sampled on the falling edge after the edge at which the frame sync is first seen high. With `cfg_early`=0 the first data bit is sampled on that same edge.
- R4: A frame starts when the frame sync is low at one sampling edge and high at the next. A frame sync that stays high for a whole word gives the same result as a one-bit frame sync.
- R5: With `cfg_mode`=0 (normal; a value of 3 behaves the same), each frame delivers exactly one word with slot tag 0. Bits after that word are ignored until the next frame start.
- R6: With `cfg_mode`=1 (network), a frame holds `cfg_slots_m1`+1 consecutive words, numbered 0 upward. A word is stored only if bit `slot` of `cfg_slot_en` is 1, and its tag is that slot number. Bits after the last slot are ignored.
- R7: With `cfg_mode`=2 (gated), the frame sync is ignored. Each run of word-length falling edges forms one word, even when the clock pauses partway through. The tag is 0.
- R8: A frame start that arrives partway through a word throws away the partial word and starts counting bits again.
- R9: The FIFO holds 4 words and delivers them in arrival order. `out_valid` is high while it is not empty, and one word is removed on each cycle where `out_valid` and `out_ready` are both high. While the output is stalled, the word and tag stay stable.
- R10: A word that completes while the FIFO already holds 4 words is dropped and sets `overrun`. `overrun` stays set until reset.
- R11: After reset `out_valid` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sync | input | 1 | 1: use transmit-side bit clock and frame sync |
| cfg_mode | input | 2 | 0 normal, 1 network, 2 gated |
| cfg_wlen | input | 2 | Word length code (8/10/12/16) |
| cfg_early | input | 1 | 1: frame sync leads the first data bit by one bit |
| cfg_slots_m1 | input | 5 | Slots per network frame minus one |
| cfg_slot_en | input | 32 | Per-slot store enable, bit n for slot n |
| rx_bclk | input | 1 | Receiver's own bit clock |
| rx_fs | input | 1 | Receiver's own frame sync |
| tx_bclk | input | 1 | Transmit-side bit clock |
| tx_fs | input | 1 | Transmit-side frame sync |
| rx_data | input | 1 | Serial data in |
| out_valid | output | 1 | FIFO holds a word |
| out_ready | input | 1 | Consumer takes the head word |
| out_word | output | 16 | Received word, right-justified |
| out_slot | output | 5 | Slot the word arrived in |
| overrun | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The main test is a table of single-word normal frames. Its rows cover every word length, both frame-sync positions, both frame-sync lengths and both clock sources, with data whose upper bits are ones. A wrong length, a shift of one bit or the wrong clock source therefore each give a different word. Network frames with a sparse enable mask separate slot counting from slot filtering. A gated burst that pauses mid-word and carries stray frame-sync pulses shows that gated mode counts clock edges only. A frame sync restarting a partly received word, and five words pushed into a stalled FIFO, cover restart, ordering and overrun.

// File: rtl/ssa_rx_pkg.sv
package ssa_rx_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_SLOTS = 32;
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int CNT_W     = $clog2(WORD_W);

  typedef struct packed {
    logic [SLOT_W-1:0] slot;
    logic [WORD_W-1:0] word;
  } rx_entry_t;

  // index of the last bit of a word for a length code
  function automatic logic [CNT_W-1:0] wl_last(input logic [1:0] code);
    case (code)
      2'd0:    wl_last = CNT_W'(7);
      2'd1:    wl_last = CNT_W'(9);
      2'd2:    wl_last = CNT_W'(11);
      default: wl_last = CNT_W'(15);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] wl_mask(input logic [1:0] code);
    case (code)
      2'd0:    wl_mask = WORD_W'(16'h00FF);
      2'd1:    wl_mask = WORD_W'(16'h03FF);
      2'd2:    wl_mask = WORD_W'(16'h0FFF);
      default: wl_mask = WORD_W'(16'hFFFF);
    endcase
  endfunction
endpackage

// File: rtl/ssa_rx_edge.sv
module ssa_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sync,
  input  logic rx_bclk,
  input  logic rx_fs,
  input  logic tx_bclk,
  input  logic tx_fs,
  input  logic rx_data,
  output logic bit_ev,
  output logic fs_s,
  output logic dat_s
);
  logic bclk_sel, fs_sel;
  logic bclk_q, bclk_qq;

  always_comb begin
    bclk_sel = sel_sync ? tx_bclk : rx_bclk;
    fs_sel   = sel_sync ? tx_fs   : rx_fs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bclk_qq <= 1'b0;
      fs_s    <= 1'b0;
      dat_s   <= 1'b0;
    end else begin
      bclk_q  <= bclk_sel;
      bclk_qq <= bclk_q;
      fs_s    <= fs_sel;
      dat_s   <= rx_data;
    end
  end

  // falling edge of the selected bit clock
  assign bit_ev = bclk_qq & ~bclk_q;
endmodule

// File: rtl/ssa_rx_frame.sv
module ssa_rx_frame
  import ssa_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_ev,
  input  logic                 fs_s,
  input  logic                 dat_s,
  input  logic [1:0]           mode,
  input  logic [1:0]           wlen,
  input  logic                 early,
  input  logic [SLOT_W-1:0]    slots_m1,
  input  logic [MAX_SLOTS-1:0] slot_en,
  output logic                 push,
  output rx_entry_t            entry
);
  logic [WORD_W-1:0] sh_q, sh_n, shifted;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [SLOT_W-1:0] slot_q, slot_n;
  logic              act_q, act_n, fsp_q, fsp_n;
  logic              push_n;
  rx_entry_t         ent_n;
  logic              gated, network, last_bit;

  always_comb begin
    gated    = (mode == 2'd2);
    network  = (mode == 2'd1);
    shifted  = {sh_q[WORD_W-2:0], dat_s};
    last_bit = (cnt_q == wl_last(wlen));
    sh_n     = sh_q;
    cnt_n    = cnt_q;
    slot_n   = slot_q;
    act_n    = act_q;
    fsp_n    = fsp_q;
    push_n   = 1'b0;
    ent_n.word = shifted & wl_mask(wlen);
    ent_n.slot = '0;
    if (bit_ev) begin
      fsp_n = fs_s;
      if (gated) begin
        sh_n = shifted;
        if (last_bit) begin
          push_n = 1'b1;
          cnt_n  = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else if (fs_s && !fsp_q) begin
        act_n  = 1'b1;
        slot_n = '0;
        if (early) begin
          cnt_n = '0;
        end else begin
          sh_n  = shifted;
          cnt_n = CNT_W'(1);
        end
      end else if (act_q) begin
        sh_n = shifted;
        if (last_bit) begin
          cnt_n      = '0;
          ent_n.slot = network ? slot_q : '0;
          push_n     = network ? slot_en[slot_q] : 1'b1;
          slot_n     = slot_q + 1'b1;
          if (!network || slot_q == slots_m1) act_n = 1'b0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      slot_q <= '0;
      act_q  <= 1'b0;
      fsp_q  <= 1'b0;
      push   <= 1'b0;
      entry  <= '0;
    end else begin
      push <= push_n;
      if (bit_ev) begin
        sh_q   <= sh_n;
        cnt_q  <= cnt_n;
        slot_q <= slot_n;
        act_q  <= act_n;
        fsp_q  <= fsp_n;
      end
      if (push_n) entry <= ent_n;
    end
  end
endmodule

// File: rtl/ssa_rx_fifo.sv
module ssa_rx_fifo
  import ssa_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  rx_entry_t wr_entry,
  output logic      rd_valid,
  input  logic      rd_ready,
  output rx_entry_t rd_entry,
  output logic      ovr
);
  localparam int AW = $clog2(DEPTH);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q, cnt_n;
  logic          full, do_wr, do_rd;

  always_comb begin
    full     = (cnt_q == (AW+1)'(DEPTH));
    rd_valid = (cnt_q != '0);
    do_wr    = wr && !full;
    do_rd    = rd_valid && rd_ready;
    cnt_n    = cnt_q + (AW+1)'(do_wr) - (AW+1)'(do_rd);
    rd_entry = mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_entry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovr   <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
      if (wr && full) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/ssa_rx.sv
module ssa_rx
  import ssa_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_sync,
  input  logic [1:0]           cfg_mode,
  input  logic [1:0]           cfg_wlen,
  input  logic                 cfg_early,
  input  logic [SLOT_W-1:0]    cfg_slots_m1,
  input  logic [MAX_SLOTS-1:0] cfg_slot_en,
  input  logic                 rx_bclk,
  input  logic                 rx_fs,
  input  logic                 tx_bclk,
  input  logic                 tx_fs,
  input  logic                 rx_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [WORD_W-1:0]    out_word,
  output logic [SLOT_W-1:0]    out_slot,
  output logic                 overrun
);
  logic [1:0] rs_q;
  logic       rst_core_n;
  logic       bit_ev, fs_s, dat_s, push;
  rx_entry_t  ent_in, ent_out;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  ssa_rx_edge u_edge (
    .clk(clk), .rst_n(rst_core_n), .sel_sync(cfg_sync),
    .rx_bclk(rx_bclk), .rx_fs(rx_fs), .tx_bclk(tx_bclk), .tx_fs(tx_fs),
    .rx_data(rx_data), .bit_ev(bit_ev), .fs_s(fs_s), .dat_s(dat_s)
  );

  ssa_rx_frame u_frame (
    .clk(clk), .rst_n(rst_core_n), .bit_ev(bit_ev), .fs_s(fs_s), .dat_s(dat_s),
    .mode(cfg_mode), .wlen(cfg_wlen), .early(cfg_early),
    .slots_m1(cfg_slots_m1), .slot_en(cfg_slot_en),
    .push(push), .entry(ent_in)
  );

  ssa_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_core_n), .wr(push), .wr_entry(ent_in),
    .rd_valid(out_valid), .rd_ready(out_ready), .rd_entry(ent_out), .ovr(overrun)
  );

  assign out_word = ent_out.word;
  assign out_slot = ent_out.slot;
endmodule

// File: rtl/ssa_rx_chk.sv
module ssa_rx_chk
  import ssa_rx_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cfg_mode,
  input logic [1:0]           cfg_wlen,
  input logic [MAX_SLOTS-1:0] cfg_slot_en,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [WORD_W-1:0]    out_word,
  input logic [SLOT_W-1:0]    out_slot,
  input logic                 overrun
);
  // R10: overrun stays set once set
  p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  // R9: head word held while consumer stalls
  p_stall_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_slot)));

  // R1: bits above the word length are zero
  p_word_justified_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_word & ~wl_mask(cfg_wlen)) == '0));

  // R5 and R7: outside network mode the tag is slot 0
  p_tag_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mode != 2'd1) |-> (out_slot == '0));

  // R6: only enabled slots reach the output
  p_slot_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_mode == 2'd1) |-> cfg_slot_en[out_slot]);
endmodule

bind ssa_rx ssa_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_wlen(cfg_wlen),
  .cfg_slot_en(cfg_slot_en), .out_valid(out_valid), .out_ready(out_ready),
  .out_word(out_word), .out_slot(out_slot), .overrun(overrun)
);

// File: tb/ssa_rx_tb_top.sv
module ssa_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_sync = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [1:0]  cfg_wlen = 2'd0;
  logic        cfg_early = 1'b0;
  logic [4:0]  cfg_slots_m1 = 5'd0;
  logic [31:0] cfg_slot_en = 32'h0;
  logic        rx_bclk = 1'b0, rx_fs = 1'b0, tx_bclk = 1'b0, tx_fs = 1'b0;
  logic        rx_data = 1'b0;
  logic        out_valid, out_ready = 1'b0, overrun;
  logic [15:0] out_word;
  logic [4:0]  out_slot;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ssa_rx dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_sync(cfg_sync), .cfg_mode(cfg_mode),
    .cfg_wlen(cfg_wlen), .cfg_early(cfg_early), .cfg_slots_m1(cfg_slots_m1),
    .cfg_slot_en(cfg_slot_en), .rx_bclk(rx_bclk), .rx_fs(rx_fs),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .rx_data(rx_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_slot(out_slot), .overrun(overrun)
  );

  // {expected[15:0], data[15:0], sync, wlen[1:0], early, fs_long}
  localparam logic [36:0] VEC [8] = '{
    {16'h00A5, 16'hFFA5, 1'b0, 2'd0, 1'b0, 1'b0},
    {16'h02C3, 16'h02C3, 1'b0, 2'd1, 1'b1, 1'b0},
    {16'h0123, 16'hF123, 1'b0, 2'd2, 1'b0, 1'b1},
    {16'h8001, 16'h8001, 1'b0, 2'd3, 1'b1, 1'b1},
    {16'h005A, 16'h005A, 1'b1, 2'd0, 1'b1, 1'b0},
    {16'hBEEF, 16'hBEEF, 1'b1, 2'd3, 1'b0, 1'b1},
    {16'h03FF, 16'hFFFF, 1'b1, 2'd1, 1'b0, 1'b0},
    {16'h0ABC, 16'h0ABC, 1'b0, 2'd2, 1'b1, 1'b1}
  };

  function automatic int wl_of(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 10;
      2'd2: return 12;
      default: return 16;
    endcase
  endfunction

  task automatic drive_bit(input logic f, input logic d);
    rx_data = d;
    if (cfg_sync) begin tx_fs = f; tx_bclk = 1'b1; end
    else          begin rx_fs = f; rx_bclk = 1'b1; end
    repeat (4) @(negedge clk);
    if (cfg_sync) tx_bclk = 1'b0; else rx_bclk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input int nslots, input logic fs_long, input logic [63:0] words);
    int wl = wl_of(cfg_wlen);
    int lead = cfg_early ? 1 : 0;
    for (int b = 0; b < lead + nslots * wl + 3; b++) begin
      int d = b - lead;
      logic f = (b == 0) || (fs_long && b < wl);
      logic bitv = 1'b1;
      if (d >= 0 && d < nslots * wl) bitv = words[(d / wl) * 16 + wl - 1 - (d % wl)];
      drive_bit(f, bitv);
    end
    if (cfg_sync) tx_fs = 1'b0; else rx_fs = 1'b0;
  endtask

  task automatic pop_check(input logic [15:0] ew, input logic [4:0] es, input string req);
    @(negedge clk);
    n_chk++;
    if (!out_valid || out_word !== ew || out_slot !== es) begin
      n_bad++;
      $display("FAIL %s: valid=%0b word=%h slot=%0d expected word=%h slot=%0d",
               req, out_valid, out_word, out_slot, ew, es);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic exp, input string req);
    @(negedge clk);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_empty(input string req);
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out_valid got %0b expected 0 (word=%h)", req, out_valid, out_word);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R11 reset state
    check_bit(out_valid, 1'b0, "R11 valid after reset");
    check_bit(overrun, 1'b0, "R11 overrun after reset");

    // R1 R2 R3 R4 R5: table of normal frames
    for (int i = 0; i < 8; i++) begin
      logic [36:0] v = VEC[i];
      cfg_mode  = 2'd0;
      cfg_sync  = v[4];
      cfg_wlen  = v[3:2];
      cfg_early = v[1];
      send_frame(1, v[0], {48'h0, v[20:5]});
      pop_check(v[36:21], 5'd0, "R1 R2 R3 R4 table word");
      check_empty("R5 trailing bits ignored");
    end

    // R8: restart on a frame start mid-word
    cfg_sync = 1'b0; cfg_wlen = 2'd0; cfg_early = 1'b0;
    drive_bit(1'b1, 1'b1);
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b0, 1'b0);
    send_frame(1, 1'b0, {48'h0, 16'h003C});
    pop_check(16'h003C, 5'd0, "R8 restarted word");
    check_empty("R8 partial word discarded");

    // R7: gated capture, word split across two bursts, stray frame sync
    cfg_mode = 2'd2;
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b0, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b1, 1'b0);
    repeat (24) @(negedge clk);
    drive_bit(1'b0, 1'b1);
    drive_bit(1'b1, 1'b1);
    drive_bit(1'b0, 1'b0);
    pop_check(16'h0096, 5'd0, "R7 gated word over two bursts");
    for (int b = 7; b >= 0; b--) drive_bit(b[0], (8'h41 >> b) & 1'b1);
    pop_check(16'h0041, 5'd0, "R7 gated second word");
    check_empty("R7 no extra word");
    rx_fs = 1'b0;

    // R6: network frame, slots 1 and 3 enabled
    cfg_mode = 2'd1; cfg_early = 1'b1; cfg_slots_m1 = 5'd3; cfg_slot_en = 32'h0000_000A;
    send_frame(4, 1'b0, 64'h0044_0033_0022_0011);
    pop_check(16'h0022, 5'd1, "R6 slot 1");
    pop_check(16'h0044, 5'd3, "R6 slot 3");
    check_empty("R6 disabled slots dropped");

    // R6 R4: two 12-bit slots, word-long sync, coincident
    cfg_wlen = 2'd2; cfg_early = 1'b0; cfg_slots_m1 = 5'd1; cfg_slot_en = 32'h0000_0003;
    send_frame(4, 1'b1, 64'h0FFF_0EEE_0B0B_0A0A);
    pop_check(16'h0A0A, 5'd0, "R6 slot 0");
    pop_check(16'h0B0B, 5'd1, "R6 slot 1 last");
    check_empty("R6 bits after last slot ignored");

    // R9 R10: stalled FIFO fills, fifth word dropped
    cfg_mode = 2'd0; cfg_wlen = 2'd0; cfg_early = 1'b0; cfg_slot_en = 32'h0;
    for (int k = 1; k <= 4; k++) send_frame(1, 1'b0, {48'h0, 16'(k * 17)});
    check_bit(overrun, 1'b0, "R10 no overrun at four words");
    send_frame(1, 1'b0, {48'h0, 16'h0077});
    check_bit(overrun, 1'b1, "R10 overrun on fifth word");
    for (int k = 1; k <= 4; k++) pop_check(16'(k * 17), 5'd0, "R9 order after stall");
    check_empty("R10 dropped word absent");
    check_bit(overrun, 1'b1, "R10 overrun sticky");

    // R11: reset clears the flag
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_bit(overrun, 1'b0, "R11 overrun cleared by reset");
    check_bit(out_valid, 1'b0, "R11 empty after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule